// File: doc/BRIEF.md
# Power-Good Reset Sequencer

This controller lives in the always-on standby domain. It decides when the processors and the platform may leave reset. It watches the power supply's "rails valid" indication and a front-panel reset button. It drives a processor power-good line and an active-low bus reset line. Once the supply reports good rails, the controller waits a fixed qualification delay of nominally 500 ms before raising processor power-good. The rising edge of power-good launches a bus reset pulse of programmable length.

A front-panel press is a hard reset. It removes processor power-good and then runs the same qualification delay again. The controller's own registers are cleared only by its reset input, which comes from the standby-supply monitor, so the press does not clear them. The delay is built from a clock divider (`TICK_DIV` clocks per tick) and a tick count (`QUAL_TICKS`). A simulation can shorten it without touching the logic.

Top module: `pwrgood_seq`

## Requirements
- R1: While `rst` is high and after its release, `cpu_pwr_good_o` is 0 and `bus_reset_n_o` is 1 until a sequence completes.
- R2: With N = TICK_DIV*QUAL_TICKS and `supply_ok_i` changed between edges, `cpu_pwr_good_o` first reads 1 after the (N+3)th rising clock edge that follows the change.
- R3: `bus_reset_n_o` goes to 0 at the same edge at which `cpu_pwr_good_o` rises. It stays 0 for exactly BUS_PULSE_CYC clocks and is 1 at all other times.
- R4: When `supply_ok_i` goes low, `cpu_pwr_good_o` is 0 after the third edge that follows. The next qualification starts from zero and again takes N+3 edges from the return of `supply_ok_i`.
- R5: A high level on `fp_reset_i` that lasts fewer than DEBOUNCE_CYC clocks is ignored, and `cpu_pwr_good_o` stays high.
- R6: A press of `fp_reset_i` that lasts at least DEBOUNCE_CYC clocks, made while power-good is high, clears `cpu_pwr_good_o` after edge DEBOUNCE_CYC+3. The block then raises it again N edges later with a new bus reset pulse, and no `rst` is needed.
- R7: Holding `fp_reset_i` high counts as one press. Neither the long hold nor the release starts another sequence.
- R8: A press during qualification restarts the delay from zero. A press while `supply_ok_i` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| rst | input | 1 | Synchronous active-high reset from the standby-supply monitor |
| supply_ok_i | input | 1 | Asynchronous power-supply rails-valid indication |
| fp_reset_i | input | 1 | Asynchronous front-panel reset button, high when pressed |
| cpu_pwr_good_o | output | 1 | Processor power-good, registered |
| bus_reset_n_o | output | 1 | Active-low bus reset pulse, registered |

## Verification
The bench sweeps the moment of a supply drop across the whole qualification window. A design that kept its partial count would raise power-good too early on the retry, and one that ignored the drop would raise it at the old time. Button pulses one clock short of the debounce window, long holds and releases are aimed at the filter. A leaky filter would drop power-good on a glitch or restart it on release. Presses during qualification and with the supply off check that a restart is a full restart and that an unpowered press changes nothing. Every rise is timed to the exact edge, and every bus reset pulse is measured to the exact length, so an off-by-one in the divider, the tick counter or the pulse counter shows up as a wrong count.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_QUAL = 2'd1,
    ST_ON   = 2'd2
  } pgs_state_e;
endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pgs_debounce.sv
module pgs_debounce #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din_i,
  output logic press_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic          filt_q;
  logic [CW-1:0] run_q;
  logic          press_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q  <= 1'b0;
      run_q   <= '0;
      press_q <= 1'b0;
    end else begin
      press_q <= 1'b0;
      if (din_i == filt_q) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        filt_q  <= din_i;
        run_q   <= '0;
        press_q <= din_i;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign press_o = press_q;

  // R7: a press event is a single-cycle pulse
  a_r7_press_single: assert property (@(posedge clk) disable iff (rst)
    press_q |=> !press_q);
  // R5: the filtered level only moves after a full hold window
  a_r5_hold_window: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> ($past(run_q) == LAST));
endmodule

// File: rtl/pgs_tick_div.sv
module pgs_tick_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic tick_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] TOP = DW'(DIV - 1);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)      cnt_q <= '0;
    else if (cnt_q == TOP) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == TOP);
endmodule

// File: rtl/pgs_seq_core.sv
module pgs_seq_core
  import pgs_pkg::*;
#(
  parameter int QUAL_TICKS = 5,
  parameter int BUS_PULSE  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sup_ok_i,
  input  logic press_i,
  input  logic tick_i,
  output logic div_clr_o,
  output logic pg_o,
  output logic bus_n_o
);
  localparam int QW = (QUAL_TICKS > 1) ? $clog2(QUAL_TICKS) : 1;
  localparam int BW = $clog2(BUS_PULSE + 1);
  localparam logic [QW-1:0] QLAST = QW'(QUAL_TICKS - 1);

  pgs_state_e    state_q, state_d;
  logic          restart;
  logic [QW-1:0] qcnt_q;
  logic [BW-1:0] bcnt_q;
  logic          pg_q, busn_q;

  always_comb begin
    state_d = state_q;
    restart = 1'b0;
    unique case (state_q)
      ST_OFF:  if (sup_ok_i) state_d = ST_QUAL;
      ST_QUAL: begin
        if (!sup_ok_i)                      state_d = ST_OFF;
        else if (press_i)                   restart = 1'b1;
        else if (tick_i && qcnt_q == QLAST) state_d = ST_ON;
      end
      ST_ON: begin
        if (!sup_ok_i)    state_d = ST_OFF;
        else if (press_i) state_d = ST_QUAL;
      end
      default: state_d = ST_OFF;
    endcase
  end

  assign div_clr_o = (state_q != ST_QUAL) || restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      qcnt_q  <= '0;
      pg_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pg_q    <= (state_d == ST_ON);
      if (state_q != ST_QUAL || state_d != ST_QUAL || restart) qcnt_q <= '0;
      else if (tick_i)                                          qcnt_q <= qcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt_q <= '0;
      busn_q <= 1'b1;
    end else if (state_d == ST_ON && state_q != ST_ON) begin
      bcnt_q <= BW'(BUS_PULSE);
      busn_q <= 1'b0;
    end else if (bcnt_q > BW'(1)) begin
      bcnt_q <= bcnt_q - 1'b1;
    end else if (bcnt_q == BW'(1)) begin
      bcnt_q <= '0;
      busn_q <= 1'b1;
    end
  end

  assign pg_o    = pg_q;
  assign bus_n_o = busn_q;

  // R4: supply loss removes power-good at the next edge
  a_r4_supply_loss: assert property (@(posedge clk) disable iff (rst)
    !sup_ok_i |=> !pg_q);
  // R6: a press while powered drops power-good
  a_r6_press_drops: assert property (@(posedge clk) disable iff (rst)
    (press_i && pg_q) |=> !pg_q);
  // R2: power-good only rises at the end of a full qualification
  a_r2_rise_after_qual: assert property (@(posedge clk) disable iff (rst)
    $rose(pg_q) |-> ($past(state_q) == ST_QUAL && $past(qcnt_q) == QLAST));
  // R3: bus reset pulse starts with the power-good rise
  a_r3_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(pg_q) |-> !busn_q);
  // R8: with supply off, a press leaves the sequencer off
  a_r8_off_ignores: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFF && !sup_ok_i) |=> (state_q == ST_OFF));
endmodule

// File: rtl/pwrgood_seq.sv
module pwrgood_seq #(
  parameter int SYNC_STAGES   = 2,
  parameter int TICK_DIV      = 250_000,
  parameter int QUAL_TICKS    = 500,
  parameter int DEBOUNCE_CYC  = 2_500_000,
  parameter int BUS_PULSE_CYC = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic fp_reset_i,
  output logic cpu_pwr_good_o,
  output logic bus_reset_n_o
);
  logic sup_s, btn_s, press, tick, div_clr;

  pgs_sync #(.STAGES(SYNC_STAGES)) u_sync_sup (
    .clk(clk), .rst(rst), .d_i(supply_ok_i), .q_o(sup_s));

  pgs_sync #(.STAGES(SYNC_STAGES)) u_sync_btn (
    .clk(clk), .rst(rst), .d_i(fp_reset_i), .q_o(btn_s));

  pgs_debounce #(.HOLD_CYC(DEBOUNCE_CYC)) u_deb (
    .clk(clk), .rst(rst), .din_i(btn_s), .press_o(press));

  pgs_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk(clk), .rst(rst), .clr_i(div_clr), .tick_o(tick));

  pgs_seq_core #(.QUAL_TICKS(QUAL_TICKS), .BUS_PULSE(BUS_PULSE_CYC)) u_core (
    .clk(clk), .rst(rst), .sup_ok_i(sup_s), .press_i(press), .tick_i(tick),
    .div_clr_o(div_clr), .pg_o(cpu_pwr_good_o), .bus_n_o(bus_reset_n_o));

  // R1: outputs held in their safe state during reset
  a_r1_reset_safe: assert property (@(posedge clk)
    rst |=> (!cpu_pwr_good_o && bus_reset_n_o));
  // R3: bus reset is only driven low while power-good is high
  a_r3_pulse_inside_pg: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_reset_n_o) |-> cpu_pwr_good_o);
endmodule

// File: tb/pwrgood_seq_bench.sv
module pwrgood_seq_bench;
  localparam int D   = 4;
  localparam int Q   = 5;
  localparam int N   = D * Q;
  localparam int DB  = 4;
  localparam int P   = 3;
  localparam int LIM = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sup = 1'b0;
  logic btn = 1'b0;
  logic pg, busn;
  int   checks = 0;
  int   errors = 0;

  always #2 clk = ~clk;

  pwrgood_seq #(.SYNC_STAGES(2), .TICK_DIV(D), .QUAL_TICKS(Q),
                .DEBOUNCE_CYC(DB), .BUS_PULSE_CYC(P)) u_pwrgood_seq (
    .clk(clk), .rst(rst), .supply_ok_i(sup), .fp_reset_i(btn),
    .cpu_pwr_good_o(pg), .bus_reset_n_o(busn));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (!pg && n < LIM) begin step(); n++; end
  endtask

  task automatic pulse_len(input string tag);
    int lowc = 0;
    while (!busn && lowc < LIM) begin lowc++; step(); end
    chk(tag, lowc, P);
  endtask

  task automatic hold_high(input int cyc, input string tag);
    int bad = 0;
    for (int i = 0; i < cyc; i++) begin step(); if (!pg) bad++; end
    chk(tag, bad, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) step();
    chk("R1 pg in reset", pg, 0);
    chk("R1 busn in reset", busn, 1);
    rst = 1'b0;
    repeat (5) step();
    chk("R1 pg after reset", pg, 0);
    chk("R1 busn after reset", busn, 1);

    // R2/R3: power-up sequence
    sup = 1'b1;
    wait_rise(n);
    chk("R2 power-up latency", n, N + 3);
    chk("R3 busn low at rise", busn, 0);
    pulse_len("R3 pulse length");
    hold_high(5, "R3 pg stays high");
    chk("R3 busn idle high", busn, 1);

    // R4: sweep drop point across qualification window
    for (int k = 1; k <= N + 2; k++) begin
      int early = 0;
      sup = 1'b0;
      repeat (3) step();
      chk("R4 pg off after drop", pg, 0);
      repeat (2) step();
      sup = 1'b1;
      for (int i = 0; i < k; i++) begin step(); if (pg) early++; end
      sup = 1'b0;
      repeat (3) step();
      chk("R4 no early rise", early + pg, 0);
      repeat (2) step();
      sup = 1'b1;
      wait_rise(n);
      chk("R4 restart latency", n, N + 3);
      pulse_len("R3 pulse after retry");
      step();
    end

    // R5: glitch one clock short of debounce window
    btn = 1'b1;
    repeat (DB - 1) step();
    btn = 1'b0;
    hold_high(2 * N, "R5 glitch ignored");

    // R6: real press
    btn = 1'b1;
    n = 0;
    while (pg && n < LIM) begin step(); n++; end
    chk("R6 press to pg drop", n, DB + 3);
    wait_rise(n);
    chk("R6 reassert after press", n, N);
    chk("R6 busn low at rise", busn, 0);
    pulse_len("R6 pulse after press");

    // R7: long hold and release give no further event
    hold_high(3 * N, "R7 hold one event");
    btn = 1'b0;
    hold_high(DB + 3 * N, "R7 release no event");

    // R8: press during qualification restarts the delay
    sup = 1'b0;
    repeat (4) step();
    chk("R8 pg off before qual", pg, 0);
    sup = 1'b1;
    repeat (5) step();
    btn = 1'b1;
    wait_rise(n);
    chk("R8 restart by press", n, DB + 3 + N);
    pulse_len("R8 pulse after restart");
    btn = 1'b0;
    hold_high(DB + 4, "R8 release in on");

    // R8: press with supply off has no effect
    sup = 1'b0;
    repeat (4) step();
    btn = 1'b1;
    repeat (DB + 4) step();
    chk("R8 pg off during press", pg, 0);
    btn = 1'b0;
    repeat (DB + 4) step();
    chk("R8 busn idle off", busn, 1);
    sup = 1'b1;
    wait_rise(n);
    chk("R8 latency after off press", n, N + 3);
    pulse_len("R3 final pulse");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule